// File: doc/BRIEF.md
# Indexed Control Register File with Flag Interrupt

This block is a byte-wide bus slave that occupies two addresses. A write to the even address loads a 7-bit pointer. A read or write at the odd address then reaches one byte of a 128-entry register file through that pointer. Most entries are plain storage. Four entries at pointer values 10 to 13 are control and status bytes, and each has its own rules:

- **Index 10 (rate byte):** its top bit is an update-in-progress indicator that the bus cannot overwrite.
- **Index 11 (mode byte):** writing it with its top bit set clears that indicator.
- **Index 12 (flag byte):** it accumulates event flags and empties when it is read.
- **Index 13 (status byte):** it ignores writes.

A level interrupt output rises with any flag event and stays high until the flag byte is read.

A separate time-keeping engine attaches through side ports. Through them it can:
- set bits in the flag byte,
- raise or drop the update-in-progress indicator,
- write the plain storage entries.

The engine also sees the rate and mode bytes on two outputs. When a bus access and an engine action hit the same entry in the same cycle, the bus access wins. Read data is registered: it appears one clock after the read strobe and holds until the next read.

Top module: `rfp_index_regfile`

## Requirements
- R1: A write at the even address (bus_a0 = 0) stores bus_wdata[6:0] as the pointer; bit 7 of the bus byte is discarded.
- R2: A read at the even address returns 0xFF on bus_rdata.
- R3: A bus write to index 10 leaves bit 7 of index 10 unchanged and takes bits 6:0 from the bus, even when an engine update-in-progress set or clear arrives in the same cycle.
- R4: Bus writes to index 12 and index 13 have no effect.
- R5: A bus read of index 12 returns its current contents. At that clock edge the byte becomes 0x00 and irq goes low. A flag set arriving in the same cycle is dropped.
- R6: A bus write to index 11 stores the whole byte. If bit 7 of that byte is 1, bit 7 of index 10 becomes 0, and this clear wins over an engine set in the same cycle.
- R7: After reset, index 10 reads 0x26, index 11 reads 0x02, index 12 reads 0x00 and index 13 reads 0x80. Every other index reads 0x00, the pointer is 0, and irq is low.
- R8: Every index other than 10 to 13, from 0 to 127, is plain read/write byte storage.
- R9: Each bit set on eng_flag_set is ORed into index 12. Any non-zero eng_flag_set raises irq, which then stays high until index 12 is read.
- R10: eng_wr_en writes eng_wr_data into the plain entry at eng_wr_idx. A bus write to the same index in the same cycle wins. Engine writes to indices 10 to 13 are ignored.
- R11: eng_uip_set makes bit 7 of index 10 one and eng_uip_clr makes it zero; clear wins over set.
- R12: bus_rdata is updated one clock after a read strobe and keeps its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_a0 | input | 1 | 0 = pointer address, 1 = data address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| irq | output | 1 | Level interrupt, high until the flag byte is read |
| eng_flag_set | input | 8 | Engine flag bits ORed into index 12 |
| eng_uip_set | input | 1 | Engine raises the update-in-progress bit |
| eng_uip_clr | input | 1 | Engine drops the update-in-progress bit |
| eng_wr_en | input | 1 | Engine write strobe for plain entries |
| eng_wr_idx | input | 7 | Engine write index |
| eng_wr_data | input | 8 | Engine write byte |
| ctl_rate | output | 8 | Current contents of index 10 |
| ctl_mode | output | 8 | Current contents of index 11 |

## Verification
Most internal errors show up at the ports within one or two cycles:
- A corrupted pointer shows up as the wrong byte on the very next data read.
- A wrongly kept or lost update-in-progress bit shows in bit 7 of the next read of index 10. It shows at once on ctl_rate.
- A flag byte that fails to clear, or an interrupt that fails to latch or drop, is visible on irq in the cycle after the event, and again on a second read of index 12.

The same-cycle collisions between bus and engine are driven on purpose, because a wrong priority leaves no trace until the affected entry is read back.

// File: rtl/rfp_pkg.sv
// Package: shared sizes, control-entry indices and reset values for the
// indexed register file. Assumes the update-in-progress and mode-set bits
// are the most significant bit of their bytes.
package rfp_pkg;
    parameter int DW = 8;
    parameter int IW = 7;
    localparam int DEPTH = 1 << IW;

    localparam logic [IW-1:0] IX_RATE = 7'd10;
    localparam logic [IW-1:0] IX_MODE = 7'd11;
    localparam logic [IW-1:0] IX_FLAG = 7'd12;
    localparam logic [IW-1:0] IX_STAT = 7'd13;

    localparam logic [DW-1:0] RST_RATE = 8'h26;
    localparam logic [DW-1:0] RST_MODE = 8'h02;
    localparam logic [DW-1:0] RST_FLAG = 8'h00;
    localparam logic [DW-1:0] RST_STAT = 8'h80;
    localparam logic [DW-1:0] EVEN_RD  = 8'hFF;

    // True for the four entries handled by the control block
    function automatic logic is_ctl(input logic [IW-1:0] ix);
        return (ix >= IX_RATE) && (ix <= IX_STAT);
    endfunction
endpackage

// File: rtl/rfp_bus_decode.sv
// Bus decode: holds the pointer register and splits a bus strobe into
// pointer write, data write, data read and pointer-address read.
// Assumes one strobe cycle per access.
module rfp_bus_decode #(
    parameter int DW = rfp_pkg::DW,
    parameter int IW = rfp_pkg::IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          we,
    input  logic          a0,
    input  logic [DW-1:0] wdata,
    output logic [IW-1:0] idx,
    output logic          data_wr,
    output logic          data_rd,
    output logic          port_rd
);
    logic idx_wr;

    // Strobe decode
    always_comb begin
        idx_wr  = cs && we && !a0;
        data_wr = cs && we && a0;
        data_rd = cs && !we && a0;
        port_rd = cs && !we && !a0;
    end

    // Pointer register, upper bus bit discarded
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (idx_wr)
            idx <= wdata[IW-1:0];
    end

    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we && !a0) |=> (idx == $past(wdata[IW-1:0])))
        else $error("pointer load"); // R1
endmodule

// File: rtl/rfp_ctl_regs.sv
// Control entries 10..13: rate byte with protected update-in-progress bit,
// mode byte, clear-on-read flag byte and a write-ignoring status byte, plus
// the latched interrupt. Assumes idx/data strobes come from rfp_bus_decode.
module rfp_ctl_regs #(
    parameter int DW = rfp_pkg::DW,
    parameter int IW = rfp_pkg::IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] idx,
    input  logic          data_wr,
    input  logic          data_rd,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] flag_set,
    input  logic          uip_set,
    input  logic          uip_clr,
    output logic [DW-1:0] reg_rate,
    output logic [DW-1:0] reg_mode,
    output logic [DW-1:0] reg_flag,
    output logic [DW-1:0] reg_stat,
    output logic          irq
);
    import rfp_pkg::*;

    logic hit_rate, hit_mode, rd_flag, mode_clr_uip;

    // Entry hit decode
    always_comb begin
        hit_rate     = data_wr && (idx == IX_RATE);
        hit_mode     = data_wr && (idx == IX_MODE);
        rd_flag      = data_rd && (idx == IX_FLAG);
        mode_clr_uip = hit_mode && wdata[DW-1];
    end

    // Rate byte: low bits from bus, top bit owned by engine and mode writes
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rate <= RST_RATE;
        else if (hit_rate)
            reg_rate <= {reg_rate[DW-1], wdata[DW-2:0]};
        else if (mode_clr_uip || uip_clr)
            reg_rate[DW-1] <= 1'b0;
        else if (uip_set)
            reg_rate[DW-1] <= 1'b1;
    end

    // Mode byte: full bus write
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_mode <= RST_MODE;
        else if (hit_mode)
            reg_mode <= wdata;
    end

    // Flag byte: engine ORs bits in, bus read empties it
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_flag <= RST_FLAG;
        else if (rd_flag)
            reg_flag <= '0;
        else
            reg_flag <= reg_flag | flag_set;
    end

    // Status byte: holds its reset value, bus writes ignored
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_stat <= RST_STAT;
        else
            reg_stat <= reg_stat;
    end

    // Interrupt latch: set by any flag event, dropped by a flag read
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (rd_flag)
            irq <= 1'b0;
        else if (|flag_set)
            irq <= 1'b1;
    end

    AST_UIP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        hit_rate |=> (reg_rate[DW-1] == $past(reg_rate[DW-1])) &&
                     (reg_rate[DW-2:0] == $past(wdata[DW-2:0])))
        else $error("rate write"); // R3
    AST_MODE_CLR_UIP: assert property (@(posedge clk) disable iff (!rst_n)
        mode_clr_uip |=> !reg_rate[DW-1])
        else $error("mode clears uip"); // R6
    AST_FLAG_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_flag |=> (reg_flag == '0))
        else $error("flag clear"); // R5
    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_flag |=> !irq)
        else $error("irq drop"); // R5
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_flag) |=> irq)
        else $error("irq hold"); // R9
    AST_FLAG_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        ((|flag_set) && !rd_flag) |=> (irq && ((reg_flag & $past(flag_set)) == $past(flag_set))))
        else $error("flag raise"); // R9
endmodule

// File: rtl/rfp_store.sv
// Plain byte storage for all non-control entries. The bus write port has
// priority over the engine write port on the same entry. Control slots
// generate no storage and read as zero (the top never selects them).
module rfp_store #(
    parameter int DW = rfp_pkg::DW,
    parameter int IW = rfp_pkg::IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [IW-1:0] bus_idx,
    input  logic [DW-1:0] bus_data,
    input  logic          eng_wr,
    input  logic [IW-1:0] eng_idx,
    input  logic [DW-1:0] eng_data,
    output logic [DW-1:0] rd_byte
);
    import rfp_pkg::*;
    localparam int N = 1 << IW;

    logic [DW-1:0] mem [N];

    for (genvar g = 0; g < N; g++) begin : g_ent
        if (is_ctl(IW'(g))) begin : g_hole
            assign mem[g] = '0;
        end else begin : g_byte
            // One storage byte, bus write first
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[g] <= '0;
                else if (bus_wr && (bus_idx == IW'(g)))
                    mem[g] <= bus_data;
                else if (eng_wr && (eng_idx == IW'(g)))
                    mem[g] <= eng_data;
            end
        end
    end

    // Read port follows the bus pointer
    assign rd_byte = mem[bus_idx];
endmodule

// File: rtl/rfp_index_regfile.sv
// Top: two-address indexed register file. Ties decode, control entries and
// storage together and registers the read byte. Assumes single-cycle bus
// strobes and an engine that drives its side ports synchronously.
module rfp_index_regfile #(
    parameter int DW = rfp_pkg::DW,
    parameter int IW = rfp_pkg::IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_cs,
    input  logic          bus_we,
    input  logic          bus_a0,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    input  logic [DW-1:0] eng_flag_set,
    input  logic          eng_uip_set,
    input  logic          eng_uip_clr,
    input  logic          eng_wr_en,
    input  logic [IW-1:0] eng_wr_idx,
    input  logic [DW-1:0] eng_wr_data,
    output logic [DW-1:0] ctl_rate,
    output logic [DW-1:0] ctl_mode
);
    import rfp_pkg::*;

    logic [IW-1:0] idx;
    logic          data_wr, data_rd, port_rd;
    logic [DW-1:0] reg_rate, reg_mode, reg_flag, reg_stat;
    logic [DW-1:0] store_byte, sel_byte;

    rfp_bus_decode #(.DW(DW), .IW(IW)) u_dec (
        .clk(clk), .rst_n(rst_n), .cs(bus_cs), .we(bus_we), .a0(bus_a0),
        .wdata(bus_wdata), .idx(idx), .data_wr(data_wr), .data_rd(data_rd),
        .port_rd(port_rd)
    );

    rfp_ctl_regs #(.DW(DW), .IW(IW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .idx(idx), .data_wr(data_wr),
        .data_rd(data_rd), .wdata(bus_wdata), .flag_set(eng_flag_set),
        .uip_set(eng_uip_set), .uip_clr(eng_uip_clr), .reg_rate(reg_rate),
        .reg_mode(reg_mode), .reg_flag(reg_flag), .reg_stat(reg_stat),
        .irq(irq)
    );

    rfp_store #(.DW(DW), .IW(IW)) u_store (
        .clk(clk), .rst_n(rst_n), .bus_wr(data_wr), .bus_idx(idx),
        .bus_data(bus_wdata), .eng_wr(eng_wr_en), .eng_idx(eng_wr_idx),
        .eng_data(eng_wr_data), .rd_byte(store_byte)
    );

    // Read source select by pointer
    always_comb begin
        unique case (idx)
            IX_RATE: sel_byte = reg_rate;
            IX_MODE: sel_byte = reg_mode;
            IX_FLAG: sel_byte = reg_flag;
            IX_STAT: sel_byte = reg_stat;
            default: sel_byte = store_byte;
        endcase
    end

    // Registered read byte, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (port_rd)
            bus_rdata <= EVEN_RD;
        else if (data_rd)
            bus_rdata <= sel_byte;
    end

    assign ctl_rate = reg_rate;
    assign ctl_mode = reg_mode;

    AST_EVEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_we && !bus_a0) |=> (bus_rdata == 8'hFF))
        else $error("even read"); // R2
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cs && !bus_we) |=> $stable(bus_rdata))
        else $error("rdata hold"); // R12
endmodule

// File: tb/tb_rfp_index_regfile.sv
// Scoreboard bench: driver tasks push expected read bytes into a queue; a
// monitor pops one per completed bus read and compares it with bus_rdata.
module tb_rfp_index_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs = 1'b0, bus_we = 1'b0, bus_a0 = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic [7:0] eng_flag_set = '0;
    logic       eng_uip_set = 1'b0, eng_uip_clr = 1'b0, eng_wr_en = 1'b0;
    logic [6:0] eng_wr_idx = '0;
    logic [7:0] eng_wr_data = '0;
    logic [7:0] ctl_rate, ctl_mode;

    int         n_chk = 0;
    int         n_fail = 0;
    logic       rd_pend = 1'b0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #5 clk = ~clk;

    rfp_index_regfile dut (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_a0(bus_a0), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .eng_flag_set(eng_flag_set), .eng_uip_set(eng_uip_set),
        .eng_uip_clr(eng_uip_clr), .eng_wr_en(eng_wr_en),
        .eng_wr_idx(eng_wr_idx), .eng_wr_data(eng_wr_data),
        .ctl_rate(ctl_rate), .ctl_mode(ctl_mode)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Note which edges captured a bus read
    always @(posedge clk) rd_pend <= rst_n && bus_cs && !bus_we;

    // Monitor: compare read byte one cycle after the read strobe
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R12: unexpected read, actual %h expected none", bus_rdata);
            end else begin
                chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic cyc(input logic cs, we, a0, input logic [7:0] wd,
                       input logic [7:0] fs, input logic us, uc, swe,
                       input logic [6:0] sidx, input logic [7:0] sd);
        @(negedge clk);
        bus_cs = cs; bus_we = we; bus_a0 = a0; bus_wdata = wd;
        eng_flag_set = fs; eng_uip_set = us; eng_uip_clr = uc;
        eng_wr_en = swe; eng_wr_idx = sidx; eng_wr_data = sd;
        @(negedge clk);
        bus_cs = 0; bus_we = 0; bus_a0 = 0; bus_wdata = '0;
        eng_flag_set = '0; eng_uip_set = 0; eng_uip_clr = 0;
        eng_wr_en = 0; eng_wr_idx = '0; eng_wr_data = '0;
    endtask

    task automatic set_idx(input logic [7:0] i);
        cyc(1, 1, 0, i, 8'h00, 0, 0, 0, 7'd0, 8'h00);
    endtask
    task automatic wr(input logic [7:0] d);
        cyc(1, 1, 1, d, 8'h00, 0, 0, 0, 7'd0, 8'h00);
    endtask
    task automatic rd(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        cyc(1, 0, 1, 8'h00, 8'h00, 0, 0, 0, 7'd0, 8'h00);
    endtask
    task automatic wr_at(input logic [7:0] i, input logic [7:0] d);
        set_idx(i); wr(d);
    endtask
    task automatic rd_at(input logic [7:0] i, input logic [7:0] exp, input string tag);
        set_idx(i); rd(exp, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R7 reset state
        chk({7'd0, irq}, 8'h00, "R7 irq after reset");
        rd(8'h00, "R7 pointer 0 after reset");
        rd_at(8'd10, 8'h26, "R7 index 10 reset");
        rd_at(8'd11, 8'h02, "R7 index 11 reset");
        rd_at(8'd12, 8'h00, "R7 index 12 reset");
        rd_at(8'd13, 8'h80, "R7 index 13 reset");
        rd_at(8'd100, 8'h00, "R7 plain entry reset");
        chk(ctl_rate, 8'h26, "R7 ctl_rate reset");
        chk(ctl_mode, 8'h02, "R7 ctl_mode reset");
        // R2 even read
        exp_q.push_back(8'hFF); tag_q.push_back("R2 even read");
        cyc(1, 0, 0, 8'h00, 8'h00, 0, 0, 0, 7'd0, 8'h00);
        // R1 pointer bit 7 discarded, R8 plain storage
        set_idx(8'h85); wr(8'h5A);
        rd_at(8'h05, 8'h5A, "R1 pointer ignores bit 7");
        wr_at(8'd127, 8'hC3);
        rd_at(8'd127, 8'hC3, "R8 top entry");
        wr_at(8'd1, 8'hFF);
        rd_at(8'd1, 8'hFF, "R8 entry 1");
        wr_at(8'd0, 8'h3C);
        rd_at(8'd0, 8'h3C, "R8 entry 0");
        // R12 read byte holds across writes
        rd_at(8'd5, 8'h5A, "R8 entry 5 again");
        wr_at(8'd6, 8'h77);
        chk(bus_rdata, 8'h5A, "R12 rdata held");
        // R11 engine set / clear of update bit, R3 bus write keeps it
        cyc(0, 0, 0, 8'h00, 8'h00, 1, 0, 0, 7'd0, 8'h00);
        rd_at(8'd10, 8'hA6, "R11 uip set");
        wr_at(8'd10, 8'h05);
        rd_at(8'd10, 8'h85, "R3 bit 7 kept high");
        cyc(0, 0, 0, 8'h00, 8'h00, 1, 1, 0, 7'd0, 8'h00);
        rd_at(8'd10, 8'h05, "R11 clear wins over set");
        wr_at(8'd10, 8'hFF);
        rd_at(8'd10, 8'h7F, "R3 bit 7 kept low");
        set_idx(8'd10);
        cyc(1, 1, 1, 8'h26, 8'h00, 1, 0, 0, 7'd0, 8'h00);
        rd_at(8'd10, 8'h26, "R3 bus write beats engine set");
        // R6 mode write with bit 7
        cyc(0, 0, 0, 8'h00, 8'h00, 1, 0, 0, 7'd0, 8'h00);
        chk(ctl_rate, 8'hA6, "R11 ctl_rate shows uip");
        wr_at(8'd11, 8'h82);
        rd_at(8'd10, 8'h26, "R6 mode write clears uip");
        rd_at(8'd11, 8'h82, "R6 mode byte stored");
        set_idx(8'd11);
        cyc(1, 1, 1, 8'h80, 8'h00, 1, 0, 0, 7'd0, 8'h00);
        rd_at(8'd10, 8'h26, "R6 clear beats engine set");
        wr_at(8'd11, 8'h02);
        chk(ctl_mode, 8'h02, "R6 ctl_mode restored");
        // R4 protected entries
        wr_at(8'd12, 8'hFF);
        rd_at(8'd12, 8'h00, "R4 index 12 write ignored");
        chk({7'd0, irq}, 8'h00, "R4 irq unaffected");
        wr_at(8'd13, 8'h00);
        rd_at(8'd13, 8'h80, "R4 index 13 write ignored");
        // R9 flags accumulate, irq latches; R5 read clears
        cyc(0, 0, 0, 8'h00, 8'h90, 0, 0, 0, 7'd0, 8'h00);
        chk({7'd0, irq}, 8'h01, "R9 irq raised");
        cyc(0, 0, 0, 8'h00, 8'h20, 0, 0, 0, 7'd0, 8'h00);
        repeat (4) @(negedge clk);
        chk({7'd0, irq}, 8'h01, "R9 irq held");
        rd_at(8'd12, 8'hB0, "R5 flags returned");
        chk({7'd0, irq}, 8'h00, "R5 irq dropped");
        rd(8'h00, "R5 flags cleared");
        cyc(0, 0, 0, 8'h00, 8'h40, 0, 0, 0, 7'd0, 8'h00);
        exp_q.push_back(8'h40); tag_q.push_back("R5 read with concurrent set");
        cyc(1, 0, 1, 8'h00, 8'h80, 0, 0, 0, 7'd0, 8'h00);
        chk({7'd0, irq}, 8'h00, "R5 concurrent set dropped, irq");
        rd(8'h00, "R5 concurrent set dropped, byte");
        // R10 engine writes
        cyc(0, 0, 0, 8'h00, 8'h00, 0, 0, 1, 7'd3, 8'h45);
        rd_at(8'd3, 8'h45, "R10 engine write");
        cyc(0, 0, 0, 8'h00, 8'h00, 0, 0, 1, 7'd10, 8'h00);
        rd_at(8'd10, 8'h26, "R10 engine write to control ignored");
        cyc(0, 0, 0, 8'h00, 8'h00, 0, 0, 1, 7'd12, 8'hFF);
        rd_at(8'd12, 8'h00, "R10 engine write to flags ignored");
        set_idx(8'd4);
        cyc(1, 1, 1, 8'h11, 8'h00, 0, 0, 1, 7'd4, 8'h22);
        rd(8'h11, "R10 bus beats engine same entry");
        set_idx(8'd4);
        cyc(1, 1, 1, 8'h33, 8'h00, 0, 0, 1, 7'd6, 8'h66);
        rd(8'h33, "R10 bus entry in shared cycle");
        rd_at(8'd6, 8'h66, "R10 engine entry in shared cycle");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R12: %0d reads missing, actual %0d expected 0", exp_q.size(), exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule